// File: doc/BRIEF.md
# Galois Field Power and Logarithm Table Builder

This block fills a pair of lookup tables for a binary extension field GF(2^m): a power table that maps an exponent i to the element alpha^i, and a logarithm table that maps a nonzero element back to its exponent. A single linear-feedback sweep produces both tables. The sweep starts from the element 1 and writes one power entry and one logarithm entry on every clock. The generator polynomial is checked in two ways. Its degree is compared with m before the sweep begins. During the sweep, an early return of the register to 1 shows that the polynomial is not primitive.

Two field configurations are built in and picked by `field_sel`. Each has a degree and a generator polynomial. The production setting is degree 13 with polynomial 0x201B and degree 14 with polynomial 0x4443, giving table depths of 0x2000 and 0x4000. The default parameters use a reduced pair, degree 4 with 0x13 and degree 5 with 0x25, so that the tables stay small. After a run completes, a one-cycle lookup port reads either table. Lookups made while a run is in progress are dropped.

Top module: `gf_table_gen`

## Requirements
- R1: After reset, `done`, `busy`, `err_nonprim` and `lk_data_valid` are all low.
- R2: `field_sel` = 0 selects degree FIELD0_DEG with polynomial FIELD0_POLY, and `field_sel` = 1 selects FIELD1_DEG with FIELD1_POLY. The table depth is 2^m for the selected degree m.
- R3: After a successful run, power entry i holds alpha^i (x^i reduced modulo the polynomial) for i = 0 .. 2^m-2, and power entry 2^m-1 holds 1.
- R4: After a successful run, log entry alpha^i holds i for every i in 0 .. 2^m-2, and log entry 0 holds 0.
- R5: One entry pair is written per clock. Call the edge that samples `start` edge 0. A successful run shows `done` high for exactly one cycle, following edge 2^m+1, and `busy` is low in that same cycle.
- R6: If the highest set bit of the selected polynomial is not bit m, no sweep takes place. `err_nonprim` and `done` go high after edge 1.
- R7: If the register returns to 1 at step k > 0, the run aborts. `err_nonprim` and `done` go high after edge k+2, and the closing fix-up writes are skipped.
- R8: `err_nonprim` holds its value until the next accepted start, which clears it. A successful run leaves it low.
- R9: With `busy` low, a request on `lk_valid` returns its data on `lk_data` with `lk_data_valid` high one cycle later. `lk_kind` = 0 reads the power table at exponent `lk_addr`, and `lk_kind` = 1 reads the log table at element `lk_addr`.
- R10: A lookup made while `busy` is high is ignored: `lk_data_valid` stays low in the following cycle.
- R11: A `start` pulse while `busy` is high is ignored. The run keeps its field, its timing and its table contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a table build (accepted only when idle) |
| field_sel | input | 1 | Field choice: 0 for configuration 0, 1 for configuration 1 |
| busy | output | 1 | A build is in progress |
| done | output | 1 | One-cycle pulse at the end of a build or an abort |
| err_nonprim | output | 1 | Polynomial is of the wrong degree or is not primitive |
| lk_valid | input | 1 | Lookup request |
| lk_kind | input | 1 | 0 selects the power table, 1 selects the log table |
| lk_addr | input | W | Exponent or field element to look up |
| lk_data | output | W | Lookup result |
| lk_data_valid | output | 1 | `lk_data` holds the answer to the previous request |

## Verification
Every result has a fixed latency counted from the edge that samples `start`. The degree error shows after edge 1. An abort at step k shows after edge k+2. A complete build shows after edge 2^m+1, because the check state, 2^m-1 sweep steps and the fix-up step each take one register stage. The bench counts falling edges from that sampling edge and compares the count at which `done` is first seen with these numbers. It then checks on the next falling edge that the pulse has ended. Lookups are sampled on the falling edge one cycle after the request, and that is also where the bench confirms that a request made during a build returned no valid data.

// File: rtl/gf_table_pkg.sv
package gf_table_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_SWEEP = 2'd2,
    ST_FIX   = 2'd3
  } gen_state_t;

  // Production field pair
  localparam logic [31:0] GF13_POLY = 32'h0000_201B;
  localparam logic [31:0] GF14_POLY = 32'h0000_4443;

  // Index of the highest set bit, -1 for zero
  function automatic int poly_msb(logic [31:0] p);
    int r;
    r = -1;
    for (int b = 0; b < 32; b++)
      if (p[b]) r = b;
    return r;
  endfunction

  // Multiply by alpha: shift, then reduce when bit m appears
  function automatic logic [31:0] lfsr_next(logic [31:0] x, logic [31:0] p, int m);
    logic [31:0] s;
    s = x << 1;
    if (s[m]) s = s ^ p;
    return s;
  endfunction

  // 2^m - k, used for the last sweep index and the fix-up address
  function automatic logic [31:0] depth_minus(int m, int k);
    return (32'd1 << m) - 32'(k);
  endfunction

endpackage

// File: rtl/gf_table_ram.sv
module gf_table_ram #(
  parameter int AW = 5,
  parameter int DW = 5,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/gf_sweep_ctrl.sv
module gf_sweep_ctrl
  import gf_table_pkg::*;
#(
  parameter int          W          = 5,
  parameter int          FIELD0_DEG = 4,
  parameter logic [31:0] FIELD0_POLY = 32'h13,
  parameter int          FIELD1_DEG = 5,
  parameter logic [31:0] FIELD1_POLY = 32'h25
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         field_sel,
  output logic         busy,
  output logic         done,
  output logic         err_nonprim,
  // power table write port
  output logic         pw_we,
  output logic [W-1:0] pw_addr,
  output logic [W-1:0] pw_data,
  // log table write port
  output logic         lg_we,
  output logic [W-1:0] lg_addr,
  output logic [W-1:0] lg_data
);

  gen_state_t  state_q;
  logic        sel_q;
  logic [W-1:0] x_q, idx_q;
  logic        done_q, err_q;

  // Configuration of the latched field
  int          cur_deg;
  logic [31:0] cur_poly;
  logic [31:0] next32, last32, top32;
  logic [W-1:0] x_next, idx_last, addr_top;

  // Named internal events
  logic ev_accept, ev_deg_bad, ev_hit_one, ev_sweep_end, ev_sweep_wr, ev_fix_wr;

  always_comb begin
    cur_deg  = sel_q ? FIELD1_DEG : FIELD0_DEG;
    cur_poly = sel_q ? FIELD1_POLY : FIELD0_POLY;
    next32   = lfsr_next(32'(x_q), cur_poly, cur_deg);
    last32   = depth_minus(cur_deg, 2);
    top32    = depth_minus(cur_deg, 1);
    x_next   = next32[W-1:0];
    idx_last = last32[W-1:0];
    addr_top = top32[W-1:0];
  end

  assign ev_accept    = (state_q == ST_IDLE) && start;
  assign ev_deg_bad   = (state_q == ST_CHECK) && (poly_msb(cur_poly) != cur_deg);
  assign ev_hit_one   = (state_q == ST_SWEEP) && (idx_q != '0) && (x_q == W'(1));
  assign ev_sweep_wr  = (state_q == ST_SWEEP) && !ev_hit_one;
  assign ev_sweep_end = ev_sweep_wr && (idx_q == idx_last);
  assign ev_fix_wr    = (state_q == ST_FIX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sel_q   <= 1'b0;
      x_q     <= '0;
      idx_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (ev_accept) begin
            sel_q   <= field_sel;
            err_q   <= 1'b0;
            state_q <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (ev_deg_bad) begin
            err_q   <= 1'b1;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            x_q     <= W'(1);
            idx_q   <= '0;
            state_q <= ST_SWEEP;
          end
        end
        ST_SWEEP: begin
          if (ev_hit_one) begin
            err_q   <= 1'b1;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (ev_sweep_end) begin
            state_q <= ST_FIX;
          end else begin
            x_q   <= x_next;
            idx_q <= idx_q + W'(1);
          end
        end
        ST_FIX: begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    pw_we   = ev_sweep_wr || ev_fix_wr;
    lg_we   = ev_sweep_wr || ev_fix_wr;
    pw_addr = ev_fix_wr ? addr_top : idx_q;
    pw_data = ev_fix_wr ? W'(1)    : x_q;
    lg_addr = ev_fix_wr ? '0       : x_q;
    lg_data = ev_fix_wr ? '0       : idx_q;
  end

  assign busy        = (state_q != ST_IDLE);
  assign done        = done_q;
  assign err_nonprim = err_q;

  AST_X_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SWEEP) |-> (x_q != '0)); // R3
  AST_X_IN_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SWEEP) |-> ((32'(x_q) >> cur_deg) == 32'd0)); // R2
  AST_NO_FIX_AFTER_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fix_wr |-> !err_q); // R7
  AST_ABORT_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit_one |=> (done && err_nonprim && !busy)); // R7
  AST_BAD_DEG_NO_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_deg_bad |=> (state_q == ST_IDLE && err_nonprim)); // R6
  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(sel_q)); // R11

endmodule

// File: rtl/gf_table_gen.sv
module gf_table_gen
  import gf_table_pkg::*;
#(
  parameter int          FIELD0_DEG  = 4,
  parameter logic [31:0] FIELD0_POLY = 32'h13,
  parameter int          FIELD1_DEG  = 5,
  parameter logic [31:0] FIELD1_POLY = 32'h25,
  localparam int         W = (FIELD0_DEG > FIELD1_DEG) ? FIELD0_DEG : FIELD1_DEG
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         field_sel,
  output logic         busy,
  output logic         done,
  output logic         err_nonprim,
  input  logic         lk_valid,
  input  logic         lk_kind,
  input  logic [W-1:0] lk_addr,
  output logic [W-1:0] lk_data,
  output logic         lk_data_valid
);

  localparam int NTAB = 2; // 0: power table, 1: log table

  logic         tab_we    [NTAB];
  logic [W-1:0] tab_waddr [NTAB];
  logic [W-1:0] tab_wdata [NTAB];
  logic [W-1:0] tab_rdata [NTAB];
  logic         rd_en;
  logic         kind_q, rvalid_q;

  gf_sweep_ctrl #(
    .W(W),
    .FIELD0_DEG(FIELD0_DEG), .FIELD0_POLY(FIELD0_POLY),
    .FIELD1_DEG(FIELD1_DEG), .FIELD1_POLY(FIELD1_POLY)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .field_sel(field_sel),
    .busy(busy), .done(done), .err_nonprim(err_nonprim),
    .pw_we(tab_we[0]), .pw_addr(tab_waddr[0]), .pw_data(tab_wdata[0]),
    .lg_we(tab_we[1]), .lg_addr(tab_waddr[1]), .lg_data(tab_wdata[1])
  );

  assign rd_en = lk_valid && !busy;

  for (genvar t = 0; t < NTAB; t++) begin : g_tab
    gf_table_ram #(.AW(W), .DW(W)) u_ram (
      .clk(clk), .we(tab_we[t]), .waddr(tab_waddr[t]), .wdata(tab_wdata[t]),
      .re(rd_en), .raddr(lk_addr), .rdata(tab_rdata[t])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q   <= 1'b0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en;
      if (rd_en) kind_q <= lk_kind;
    end
  end

  assign lk_data       = kind_q ? tab_rdata[1] : tab_rdata[0];
  assign lk_data_valid = rvalid_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
  AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R5
  AST_READ_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_data_valid |-> (!$past(busy) && $past(lk_valid))); // R10
  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(tab_we[0] || tab_we[1])); // R9

endmodule

// File: tb/gf_table_gen_bench.sv
module gf_table_gen_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W = 5;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, field_sel = 1'b0;
  logic busy, done, err_nonprim;
  logic lk_valid = 1'b0, lk_kind = 1'b0;
  logic [W-1:0] lk_addr = '0;
  logic [W-1:0] lk_data;
  logic lk_data_valid;

  // Second instance: non-primitive degree-4 poly, wrong-degree poly for field 1
  logic b_start = 1'b0, b_sel = 1'b0;
  logic b_busy, b_done, b_err;
  logic [W-1:0] b_data;
  logic b_dvalid;

  int n_chk = 0, n_fail = 0;
  bit wd_hit = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gf_table_gen u_gf_table_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .field_sel(field_sel),
    .busy(busy), .done(done), .err_nonprim(err_nonprim),
    .lk_valid(lk_valid), .lk_kind(lk_kind), .lk_addr(lk_addr),
    .lk_data(lk_data), .lk_data_valid(lk_data_valid)
  );

  gf_table_gen #(.FIELD0_POLY(32'h1F), .FIELD1_POLY(32'h13)) u_gf_table_gen_bad (
    .clk(clk), .rst_n(rst_n), .start(b_start), .field_sel(b_sel),
    .busy(b_busy), .done(b_done), .err_nonprim(b_err),
    .lk_valid(1'b0), .lk_kind(1'b0), .lk_addr('0),
    .lk_data(b_data), .lk_data_valid(b_dvalid)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // x^i mod p by long division
  function automatic logic [63:0] pow_mod(input int i, input int m, input logic [63:0] p);
    logic [63:0] r;
    r = 64'd1 << i;
    for (int b = 63; b >= m; b--)
      if (r[b]) r = r ^ (p << (b - m));
    return r;
  endfunction

  task automatic lookup(input logic kind, input int addr,
                        output logic [W-1:0] d, output logic v);
    lk_valid = 1'b1;
    lk_kind  = kind;
    lk_addr  = addr[W-1:0];
    @(negedge clk);
    d = lk_data;
    v = lk_data_valid;
    lk_valid = 1'b0;
  endtask

  task automatic check_tables(input logic sel, input int upto);
    int m, n;
    logic [63:0] p, e;
    logic [W-1:0] d;
    logic v;
    m = sel ? 5 : 4;
    p = sel ? 64'h25 : 64'h13;
    n = 1 << m;
    for (int i = 0; i < n && i < upto; i++) begin
      lookup(1'b0, i, d, v);
      chk("R9 power valid", 64'(v), 64'd1);
      e = (i == n - 1) ? 64'd1 : pow_mod(i, m, p);
      chk(sel ? "R3 power field1" : "R3 power field0", 64'(d), e);
    end
    for (int el = 0; el < n && el < upto; el++) begin
      int lg;
      lg = 0;
      for (int i = 0; i < n - 1; i++)
        if (pow_mod(i, m, p) == 64'(el)) lg = i;
      lookup(1'b1, el, d, v);
      chk("R9 log valid", 64'(v), 64'd1);
      chk(sel ? "R4 log field1" : "R4 log field0", 64'(d), 64'(lg));
    end
  endtask

  // Runs the main instance; inject=1 adds a lookup and a start during the build
  task automatic run_main(input logic sel, input bit inject, output int n);
    @(negedge clk);
    start = 1'b1;
    field_sel = sel;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    field_sel = 1'b0;
    chk("R5 busy after start", 64'(busy), 64'd1);
    n = 0;
    while (!done && n < 200) begin
      if (inject && n == 3) begin
        lk_valid = 1'b1; lk_kind = 1'b0; lk_addr = '0;
        start = 1'b1; field_sel = ~sel;
      end
      @(negedge clk);
      n++;
      if (inject && n == 4) begin
        chk("R10 lookup while busy", 64'(lk_data_valid), 64'd0);
        lk_valid = 1'b0; start = 1'b0; field_sel = 1'b0;
      end
    end
    chk("R5 busy low with done", 64'(busy), 64'd0);
    @(negedge clk);
    chk("R5 done one cycle", 64'(done), 64'd0);
  endtask

  task automatic run_bad(input logic sel, output int n, output logic err_early);
    @(negedge clk);
    b_start = 1'b1;
    b_sel = sel;
    @(posedge clk);
    @(negedge clk);
    b_start = 1'b0;
    err_early = b_err;
    n = 0;
    while (!b_done && n < 200) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    wd_hit = 1'b1;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    int n;
    logic e0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 done", 64'(done), 64'd0);
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 err", 64'(err_nonprim), 64'd0);
    chk("R1 lk_data_valid", 64'(lk_data_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done after release", 64'(done), 64'd0);

    // Field 0: degree 4, 16 entries, done after edge 17
    run_main(1'b0, 1'b0, n);
    chk("R5 R2 field0 latency", 64'(n), 64'd17);
    chk("R8 no err field0", 64'(err_nonprim), 64'd0);
    check_tables(1'b0, 16);

    // Field 1 with lookup and start injected mid-build
    run_main(1'b1, 1'b1, n);
    chk("R11 R2 field1 latency", 64'(n), 64'd33);
    chk("R8 no err field1", 64'(err_nonprim), 64'd0);
    check_tables(1'b1, 32);

    // Back to field 0
    run_main(1'b0, 1'b0, n);
    chk("R5 field0 rerun latency", 64'(n), 64'd17);
    check_tables(1'b0, 6);

    // Non-primitive: alpha^5 = 1 under 0x1F, abort after edge 7
    run_bad(1'b0, n, e0);
    chk("R7 abort latency", 64'(n), 64'd7);
    chk("R7 err set", 64'(b_err), 64'd1);
    @(negedge clk);
    chk("R8 err held", 64'(b_err), 64'd1);

    // Wrong degree: immediate error after edge 1, and start clears old err
    run_bad(1'b1, n, e0);
    chk("R8 err cleared by start", 64'(e0), 64'd0);
    chk("R6 degree error latency", 64'(n), 64'd1);
    chk("R6 err set", 64'(b_err), 64'd1);
    @(negedge clk);
    chk("R6 no sweep busy low", 64'(b_busy), 64'd0);

    if (!wd_hit) begin
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule